// File: doc/BRIEF.md
# Trigger Timestamp Capture Unit

This block records the value of a free-running 64-bit time counter at the moment an edge is seen on one of two asynchronous trigger pins. Each pin has its own capture register. Each capture also sets a sticky flag in an event register. The same event register latches alarm and periodic-pulse indications that arrive from neighbouring logic. A mask register with the same bit layout selects which flags drive a single shared interrupt line.

Software reaches the unit through a small word-addressed register bus. The bus writes in one cycle and reads combinationally. Software can pick the active edge for each trigger, clear event flags by writing ones, program the mask, and read each captured time as a high word and a low word. The time counter and the pulse generators sit outside this block. Only their outputs enter here.

Top module: `tsu_stamp_unit`

## Requirements
- R1: After reset the event, mask and control registers, both capture registers and the interrupt output are all zero.
- R2: Trigger 0 passes through a two-flop synchronizer followed by one edge-history flop. When trigger 0 changes before rising clock edge 1, its capture register loads time_i as sampled on rising edge 3. On that same edge, event bit 24 becomes set. The bit is still clear after edge 2.
- R3: Trigger 1 behaves the same way. It loads the second capture register and sets event bit 25.
- R4: Control bit 8 selects the active edge of trigger 0 and control bit 9 selects it for trigger 1. A value of 0 means rising and 1 means falling. An edge of the other direction changes neither the capture register nor the event bit.
- R5: A high level on alarm_i[0] or alarm_i[1] during a clock edge sets event bit 16 or 17. A high level on pulse_i[0], pulse_i[1] or pulse_i[2] sets event bit 7, 6 or 5. All these bits stay set until cleared.
- R6: A bus write to the event register clears every implemented bit where the write data holds a one. It leaves the bits where the data holds a zero unchanged.
- R7: If a hardware set and a software clear hit the same event bit on the same edge, the bit ends up set.
- R8: The mask uses the event bit positions. irq_o is the OR of (event AND mask), registered, so it follows a change of the event or mask register by one cycle.
- R9: A new active edge on a channel whose event bit is still set overwrites that channel's capture register. The event bit stays set.
- R10: Bus word addresses are 0 control, 1 event, 2 mask, 3 and 4 the high and low words of capture 0, 5 and 6 the high and low words of capture 1, and 7 unused, which reads zero. Only event and mask bits 25, 24, 17, 16, 7, 6 and 5 and control bits 9 and 8 are stored. All other bits read zero. Writes to addresses 3 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| time_i | input | 64 | Running time value from the counter |
| trig_i | input | 2 | Asynchronous trigger pins |
| alarm_i | input | 2 | Alarm indications to latch |
| pulse_i | input | 3 | Periodic-pulse indications to latch |
| bus_addr_i | input | 3 | Register word address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| stamp0_o | output | 64 | Capture register of trigger 0 |
| stamp1_o | output | 64 | Capture register of trigger 1 |
| event_o | output | 32 | Event register |
| mask_o | output | 32 | Mask register |
| irq_o | output | 1 | Masked interrupt line |

## Verification
A capture lands three rising edges after the trigger pin changes. The bench moves time_i to a new value on each of those cycles, so a capture one stage early or late yields a different stored value. The bench also confirms that the event bit is still clear after the second edge. Bus writes and latched indications show in the registers one edge later. The interrupt shows one further edge after that. So each check of irq_o first samples the old level, half a cycle after the register update, and then the new level one cycle later. All sampling happens on falling clock edges.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

    // Event and mask bit positions (decoded by software)
    localparam int EV_TRIG1 = 25;
    localparam int EV_TRIG0 = 24;
    localparam int EV_ALM1  = 17;
    localparam int EV_ALM0  = 16;
    localparam int EV_PUL0  = 7;
    localparam int EV_PUL1  = 6;
    localparam int EV_PUL2  = 5;

    // Control bits selecting the falling edge per trigger
    localparam int CT_FALL0 = 8;
    localparam int CT_FALL1 = 9;

    localparam logic [31:0] EV_IMPL = (32'd1 << EV_TRIG1) | (32'd1 << EV_TRIG0)
                                    | (32'd1 << EV_ALM1)  | (32'd1 << EV_ALM0)
                                    | (32'd1 << EV_PUL0)  | (32'd1 << EV_PUL1)
                                    | (32'd1 << EV_PUL2);

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_EVENT  = 3'd1,
        A_MASK   = 3'd2,
        A_S0_HI  = 3'd3,
        A_S0_LO  = 3'd4,
        A_S1_HI  = 3'd5,
        A_S1_LO  = 3'd6,
        A_UNUSED = 3'd7
    } tsu_addr_e;

endpackage

// File: rtl/tsu_edge_detect.sv
module tsu_edge_detect #(
    parameter int N           = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] async_i,
    input  logic [N-1:0] fall_sel_i,
    output logic [N-1:0] edge_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][N-1:0] sync;
        logic [N-1:0]                  prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = async_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        st_d.prev = st_q.sync[LAST];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chan
        logic cur;
        assign cur       = st_q.sync[LAST][g];
        assign edge_o[g] = fall_sel_i[g] ? (st_q.prev[g] & ~cur)
                                         : (~st_q.prev[g] & cur);
    end

endmodule

// File: rtl/tsu_stamp_reg.sv
module tsu_stamp_reg #(
    parameter int TIME_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [TIME_W-1:0] time_i,
    output logic [TIME_W-1:0] stamp_o
);

    logic [TIME_W-1:0] stamp_d, stamp_q;

    always_comb begin
        stamp_d = stamp_q;
        if (load_i) begin
            stamp_d = time_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stamp_q <= '0;
        end else begin
            stamp_q <= stamp_d;
        end
    end

    assign stamp_o = stamp_q;

endmodule

// File: rtl/tsu_event_bank.sv
module tsu_event_bank #(
    parameter int          DW   = 32,
    parameter logic [DW-1:0] IMPL = '1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] set_i,
    input  logic [DW-1:0] clr_i,
    input  logic          mask_we_i,
    input  logic [DW-1:0] mask_wdata_i,
    output logic [DW-1:0] event_o,
    output logic [DW-1:0] mask_o,
    output logic          irq_o
);

    typedef struct packed {
        logic [DW-1:0] evt;
        logic [DW-1:0] mask;
        logic          irq;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        // Clear first, then OR in the sets: a set on the same edge wins
        bk_d.evt = ((bk_q.evt & ~clr_i) | set_i) & IMPL;
        if (mask_we_i) begin
            bk_d.mask = mask_wdata_i & IMPL;
        end
        bk_d.irq = |(bk_q.evt & bk_q.mask);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign event_o = bk_q.evt;
    assign mask_o  = bk_q.mask;
    assign irq_o   = bk_q.irq;

endmodule

// File: rtl/tsu_stamp_unit.sv
module tsu_stamp_unit
    import tsu_pkg::*;
#(
    parameter int TIME_W      = 64,
    parameter int DW          = 32,
    parameter int AW          = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TIME_W-1:0] time_i,
    input  logic [1:0]        trig_i,
    input  logic [1:0]        alarm_i,
    input  logic [2:0]        pulse_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic [TIME_W-1:0] stamp0_o,
    output logic [TIME_W-1:0] stamp1_o,
    output logic [DW-1:0]     event_o,
    output logic [DW-1:0]     mask_o,
    output logic              irq_o
);

    localparam int N_TRIG = 2;
    localparam int HI_W   = TIME_W - DW;

    // Control register: falling-edge select per trigger
    typedef struct packed {
        logic [N_TRIG-1:0] fall;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    tsu_addr_e addr;
    assign addr = tsu_addr_e'(bus_addr_i);

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_we_i && addr == A_CTRL) begin
            ctrl_d.fall[0] = bus_wdata_i[CT_FALL0];
            ctrl_d.fall[1] = bus_wdata_i[CT_FALL1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // Trigger edge detection
    logic [N_TRIG-1:0] edge_hit;

    tsu_edge_detect #(
        .N           (N_TRIG),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .async_i    (trig_i),
        .fall_sel_i (ctrl_q.fall),
        .edge_o     (edge_hit)
    );

    // Capture registers, one per channel
    logic [N_TRIG-1:0][TIME_W-1:0] stamps;

    for (genvar c = 0; c < N_TRIG; c++) begin : g_cap
        tsu_stamp_reg #(
            .TIME_W (TIME_W)
        ) i_stamp (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .load_i  (edge_hit[c]),
            .time_i  (time_i),
            .stamp_o (stamps[c])
        );
    end

    assign stamp0_o = stamps[0];
    assign stamp1_o = stamps[1];

    // Event set and clear vectors
    logic [DW-1:0] ev_set, ev_clr;

    always_comb begin
        ev_set           = '0;
        ev_set[EV_TRIG0] = edge_hit[0];
        ev_set[EV_TRIG1] = edge_hit[1];
        ev_set[EV_ALM0]  = alarm_i[0];
        ev_set[EV_ALM1]  = alarm_i[1];
        ev_set[EV_PUL0]  = pulse_i[0];
        ev_set[EV_PUL1]  = pulse_i[1];
        ev_set[EV_PUL2]  = pulse_i[2];
        ev_clr = (bus_we_i && addr == A_EVENT) ? bus_wdata_i : '0;
    end

    tsu_event_bank #(
        .DW   (DW),
        .IMPL (DW'(EV_IMPL))
    ) i_bank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .set_i        (ev_set),
        .clr_i        (ev_clr),
        .mask_we_i    (bus_we_i && addr == A_MASK),
        .mask_wdata_i (bus_wdata_i),
        .event_o      (event_o),
        .mask_o       (mask_o),
        .irq_o        (irq_o)
    );

    // Read path
    always_comb begin
        bus_rdata_o = '0;
        unique case (addr)
            A_CTRL: begin
                bus_rdata_o[CT_FALL0] = ctrl_q.fall[0];
                bus_rdata_o[CT_FALL1] = ctrl_q.fall[1];
            end
            A_EVENT:  bus_rdata_o = event_o;
            A_MASK:   bus_rdata_o = mask_o;
            A_S0_HI:  bus_rdata_o = DW'(stamps[0][TIME_W-1 -: HI_W]);
            A_S0_LO:  bus_rdata_o = stamps[0][DW-1:0];
            A_S1_HI:  bus_rdata_o = DW'(stamps[1][TIME_W-1 -: HI_W]);
            A_S1_LO:  bus_rdata_o = stamps[1][DW-1:0];
            default:  bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/tsu_stamp_unit_chk.sv
module tsu_stamp_unit_chk #(
    parameter int TIME_W = 64,
    parameter int DW     = 32,
    parameter int AW     = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [1:0]        alarm_i,
    input logic [AW-1:0]     bus_addr_i,
    input logic              bus_we_i,
    input logic [DW-1:0]     bus_wdata_i,
    input logic [DW-1:0]     bus_rdata_o,
    input logic [TIME_W-1:0] stamp0_o,
    input logic [TIME_W-1:0] stamp1_o,
    input logic [DW-1:0]     event_o,
    input logic [DW-1:0]     mask_o,
    input logic              irq_o
);

    logic [DW-1:0] sw_clr;
    assign sw_clr = (bus_we_i && bus_addr_i == AW'(1)) ? bus_wdata_i : '0;

    // R8: interrupt is last cycle's masked event OR
    a_r8_irq_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == $past(|(event_o & mask_o)));

    // R6: a set bit that was not written with one stays set
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(event_o) & ~$past(sw_clr) & ~event_o) == '0));

    // R5 and R7: an alarm level always lands in the event register
    a_r5_alarm0_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(alarm_i[0])) |-> event_o[16]);

    a_r5_alarm1_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(alarm_i[1])) |-> event_o[17]);

    // R2: capture 0 only changes together with its event flag
    a_r2_stamp0_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stamp0_o != $past(stamp0_o)) |-> event_o[24]);

    // R3: capture 1 only changes together with its event flag
    a_r3_stamp1_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stamp1_o != $past(stamp1_o)) |-> event_o[25]);

    // R10: control word reads back only the two edge-select bits
    a_r10_ctrl_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == AW'(0)) |-> ((bus_rdata_o & ~DW'(32'h300)) == '0));

endmodule

bind tsu_stamp_unit tsu_stamp_unit_chk #(
    .TIME_W (TIME_W),
    .DW     (DW),
    .AW     (AW)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alarm_i     (alarm_i),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .stamp0_o    (stamp0_o),
    .stamp1_o    (stamp1_o),
    .event_o     (event_o),
    .mask_o      (mask_o),
    .irq_o       (irq_o)
);

// File: tb/test_tsu_stamp_unit.sv
module test_tsu_stamp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_v = '0;
    logic [1:0]  trig = '0;
    logic [1:0]  alarm = '0;
    logic [2:0]  pulse = '0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] stamp0, stamp1;
    logic [31:0] event_v, mask_v;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tsu_stamp_unit i_tsu_stamp_unit (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .time_i      (time_v),
        .trig_i      (trig),
        .alarm_i     (alarm),
        .pulse_i     (pulse),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .stamp0_o    (stamp0),
        .stamp1_o    (stamp1),
        .event_o     (event_v),
        .mask_o      (mask_v),
        .irq_o       (irq)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // Drive one trigger level change with time stepping every cycle;
    // the value present on the third edge is the one to be captured.
    task automatic trig_edge(int ch, logic val, logic [63:0] base, bit pre_chk, int bit_no);
        @(negedge clk);
        trig[ch] = val; time_v = base;
        @(negedge clk);
        time_v = base + 64'd1;
        @(negedge clk);
        time_v = base + 64'd2;
        if (pre_chk) check("R2 flag not yet set after two edges", 64'(event_v[bit_no]), 64'd0);
        @(negedge clk);
        time_v = base + 64'd3;
    endtask

    task automatic hw_pulse(logic [1:0] a, logic [2:0] p);
        @(negedge clk);
        alarm = a; pulse = p;
        @(negedge clk);
        alarm = '0; pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 event", 64'(event_v), 64'd0);
        check("R1 mask", 64'(mask_v), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);
        check("R1 stamp0", stamp0, 64'd0);
        check("R1 stamp1", stamp1, 64'd0);
        bus_rd(3'd0, d);
        check("R1 ctrl", 64'(d), 64'd0);
    endtask

    task automatic t_trig0_rise();
        trig_edge(0, 1'b1, 64'h1000, 1'b1, 24);
        check("R2 stamp0 value", stamp0, 64'h1002);
        check("R2 event bit24 only", 64'(event_v), 64'h0100_0000);
        check("R2 stamp1 untouched", stamp1, 64'd0);
    endtask

    task automatic t_w1c();
        bus_wr(3'd1, 32'h0000_0000);
        check("R6 write zero keeps bit24", 64'(event_v), 64'h0100_0000);
        bus_wr(3'd1, 32'h0100_0000);
        check("R6 write one clears bit24", 64'(event_v), 64'd0);
    endtask

    task automatic t_trig1_fall();
        bus_wr(3'd0, 32'h0000_0200);
        trig_edge(1, 1'b1, 64'h7000, 1'b0, 25);
        repeat (2) @(negedge clk);
        check("R4 rising ignored on falling select stamp1", stamp1, 64'd0);
        check("R4 rising ignored on falling select bit25", 64'(event_v[25]), 64'd0);
        trig_edge(1, 1'b0, 64'h2000, 1'b1, 25);
        check("R3 stamp1 value", stamp1, 64'h2002);
        check("R3 event bit25", 64'(event_v), 64'h0200_0000);
    endtask

    task automatic t_ignore_fall0();
        trig_edge(0, 1'b0, 64'h3000, 1'b0, 24);
        repeat (2) @(negedge clk);
        check("R4 falling ignored on rising select stamp0", stamp0, 64'h1002);
        check("R4 falling ignored on rising select bit24", 64'(event_v[24]), 64'd0);
    endtask

    task automatic t_overwrite();
        trig_edge(0, 1'b1, 64'h4000, 1'b1, 24);
        check("R9 first capture", stamp0, 64'h4002);
        trig_edge(0, 1'b0, 64'h5000, 1'b0, 24);
        trig_edge(0, 1'b1, 64'h6000, 1'b0, 24);
        check("R9 overwritten capture", stamp0, 64'h6002);
        check("R9 flag stays set", 64'(event_v[24]), 64'd1);
    endtask

    task automatic t_hw_events();
        bus_wr(3'd1, 32'hFFFF_FFFF);
        check("R6 clear all", 64'(event_v), 64'd0);
        hw_pulse(2'b01, 3'b000);
        check("R5 alarm0 bit16", 64'(event_v), 64'h0001_0000);
        hw_pulse(2'b10, 3'b001);
        check("R5 alarm1 bit17 pulse0 bit7", 64'(event_v), 64'h0003_0080);
        hw_pulse(2'b00, 3'b110);
        check("R5 pulse1 bit6 pulse2 bit5", 64'(event_v), 64'h0003_00E0);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        alarm = 2'b01; addr = 3'd1; we = 1'b1; wdata = 32'h0003_0000;
        @(negedge clk);
        alarm = '0; we = 1'b0;
        check("R7 set beats clear bit16", 64'(event_v[16]), 64'd1);
        check("R7 plain clear bit17", 64'(event_v[17]), 64'd0);
    endtask

    task automatic t_irq();
        bus_wr(3'd1, 32'hFFFF_FFFF);
        hw_pulse(2'b01, 3'b001);
        @(negedge clk);
        check("R8 no irq when mask clear", 64'(irq), 64'd0);
        bus_wr(3'd2, 32'h0001_0000);
        check("R8 irq not yet after mask write", 64'(irq), 64'd0);
        @(negedge clk);
        check("R8 irq one cycle after mask", 64'(irq), 64'd1);
        bus_wr(3'd1, 32'h0001_0000);
        check("R8 irq still high right after clear", 64'(irq), 64'd1);
        @(negedge clk);
        check("R8 irq low one cycle after clear", 64'(irq), 64'd0);
        @(negedge clk);
        check("R8 unmasked bit7 raises nothing", 64'(irq), 64'd0);
        check("R8 bit7 still pending", 64'(event_v), 64'h0000_0080);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bus_rd(3'd2, d);
        check("R10 mask readback", 64'(d), 64'h0001_0000);
        bus_wr(3'd2, 32'hFFFF_FFFF);
        bus_rd(3'd2, d);
        check("R10 mask implemented bits", 64'(d), 64'h0303_00E0);
        bus_wr(3'd0, 32'hFFFF_FFFF);
        bus_rd(3'd0, d);
        check("R10 ctrl implemented bits", 64'(d), 64'h0000_0300);
        bus_rd(3'd3, d);
        check("R10 stamp0 high word", 64'(d), 64'd0);
        bus_rd(3'd4, d);
        check("R10 stamp0 low word", 64'(d), 64'h6002);
        bus_rd(3'd5, d);
        check("R10 stamp1 high word", 64'(d), 64'd0);
        bus_rd(3'd6, d);
        check("R10 stamp1 low word", 64'(d), 64'h2002);
        bus_rd(3'd7, d);
        check("R10 unused address", 64'(d), 64'd0);
        bus_wr(3'd4, 32'hDEAD_BEEF);
        bus_rd(3'd4, d);
        check("R10 capture write ignored", 64'(d), 64'h6002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_trig0_rise();
        t_w1c();
        t_trig1_fall();
        t_ignore_fall0();
        t_overwrite();
        t_hw_events();
        t_set_wins();
        t_irq();
        t_regs();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule